// File: doc/BRIEF.md
# Interrupt Arbiter and Vector Selector

This block sits in front of a 16-bit processor core and decides, at each instruction boundary, whether an interrupt is taken and which vector address the core fetches next. It holds a bitmask of level-style interrupt sources, where every source has its own set input and its own clear input. It also holds a latch for the non-maskable interrupt, which is set on the rising edge of its request line. Besides these it takes the core's interrupt-disable flag and the software break and coprocessor requests from the instruction being decoded.

There are two vector tables. One is used in emulation mode and one in native mode. The mode is a register inside the block that the core loads. In emulation mode the break instruction has no vector of its own and uses the maskable-interrupt vector. The block only arbitrates, masks and selects the vector. Stacking, opcode fetch and the rest of the datapath belong to the core. Source bit 0 is set aside for the video timer.

Top module: `intr_arbiter`

## Requirements
- R1: After reset the source mask is 0, no NMI is pending, emulation mode is 1, take_o is 0 and vector_o is 0.
- R2: On every clock, a bit of the source mask becomes 1 when its src_set_i bit is 1. It becomes 0 when its src_clr_i bit is 1 and its set bit is 0. Otherwise it keeps its value, so clearing one source leaves the other sources pending. Set wins when both are 1 on the same bit.
- R3: irq_pending_o is 1 exactly when at least one bit of the source mask is 1.
- R4: A rising edge on nmi_i makes the NMI pending, and it stays pending until it is accepted. A level that stays high does not raise a second request.
- R5: At a boundary (boundary_i = 1 at a clock edge) exactly one request is accepted, by priority: pending NMI first, then maskable interrupt, then break (brk_i), then coprocessor (cop_i).
- R6: The maskable interrupt is accepted only if the source mask is nonzero and irq_disable_i is 0. When it is blocked, a lower-priority request at the same boundary is still accepted. The NMI ignores irq_disable_i.
- R7: Accepting the NMI clears its pending latch, unless a new rising edge arrives on the same clock. Accepting the maskable interrupt leaves the source mask unchanged.
- R8: In emulation mode the vectors are NMI 0xFFFA, maskable interrupt 0xFFFE, break 0xFFFE and coprocessor 0xFFF4.
- R9: In native mode the vectors are NMI 0xFFEA, maskable interrupt 0xFFEE, break 0xFFE6 and coprocessor 0xFFE4.
- R10: take_o is 1 for exactly the one cycle after a boundary edge that accepted a request. With no boundary nothing is taken, and vector_o keeps its last value until the next boundary.
- R11: Emulation mode takes the value of emu_value_i on a clock edge where emu_load_i is 1, and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction-boundary strobe; arbitration happens on this edge |
| src_set_i | input | 8 | Per-source set bits for the source mask |
| src_clr_i | input | 8 | Per-source clear bits for the source mask |
| nmi_i | input | 1 | NMI request line, latched on its rising edge |
| irq_disable_i | input | 1 | Core's interrupt-disable flag |
| brk_i | input | 1 | Software break request |
| cop_i | input | 1 | Software coprocessor request |
| emu_load_i | input | 1 | Load strobe for the emulation-mode register |
| emu_value_i | input | 1 | Value loaded into the emulation-mode register |
| take_o | output | 1 | One-cycle strobe: an interrupt was accepted |
| vector_o | output | 16 | Vector address of the last accepted request |
| emu_mode_o | output | 1 | Current emulation mode |
| src_mask_o | output | 8 | Current source mask |
| irq_pending_o | output | 1 | OR of the source mask |
| nmi_pending_o | output | 1 | NMI latch state |

## Verification
A table of single-boundary cases covers each request type in both modes. It separates the folded break vector from the native one, and the native vectors from the emulation ones. Further rows raise several requests at the same boundary, so that each priority step is seen, including a maskable interrupt blocked by the disable flag falling through to break. Directed sequences cover overlapping set and clear bits on the mask, an NMI level held across several boundaries, and cycles with no boundary. These show that a held level does not cause a second request and that nothing is taken between boundaries.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

   typedef enum logic [2:0] {
      KIND_NONE = 3'd0,
      KIND_NMI  = 3'd1,
      KIND_IRQ  = 3'd2,
      KIND_BRK  = 3'd3,
      KIND_COP  = 3'd4
   } intr_kind_e;

   // Source bit set aside for the video timer.
   localparam int VIDEO_SRC_BIT = 0;

   // Emulation-mode table
   localparam logic [15:0] EMU_NMI_VEC = 16'hFFFA;
   localparam logic [15:0] EMU_IRQ_VEC = 16'hFFFE;
   localparam logic [15:0] EMU_COP_VEC = 16'hFFF4;

   // Native-mode table
   localparam logic [15:0] NAT_NMI_VEC = 16'hFFEA;
   localparam logic [15:0] NAT_IRQ_VEC = 16'hFFEE;
   localparam logic [15:0] NAT_BRK_VEC = 16'hFFE6;
   localparam logic [15:0] NAT_COP_VEC = 16'hFFE4;

endpackage

// File: rtl/intr_src_mask.sv
module intr_src_mask #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] mask_o,
   output logic            any_o
);

   logic [NSRC-1:0] mask_q;

   for (genvar b = 0; b < NSRC; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        mask_q[b] <= 1'b0;
         else if (set_i[b]) mask_q[b] <= 1'b1;
         else if (clr_i[b]) mask_q[b] <= 1'b0;
      end

      AST_CLR_DROPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !mask_q[b]); // R2
      AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[b] && !clr_i[b]) |=> mask_q[b]); // R2
   end

   assign mask_o = mask_q;
   assign any_o  = |mask_q;

endmodule

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_i,
   input  logic accept_i,
   output logic pend_o
);

   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = nmi_i && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= nmi_i;
         if (rise)          pend_q <= 1'b1;
         else if (accept_i) pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !accept_i) |=> pend_q); // R4
   AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && !$rose(nmi_i)) |=> !pend_q); // R7

endmodule

// File: rtl/intr_vec_sel.sv
module intr_vec_sel
   import intr_arb_pkg::*;
#(
   parameter int  VEC_W        = 16,
   parameter bit  FOLD_BRK_EMU = 1'b1
) (
   input  logic             nmi_pend_i,
   input  logic             irq_any_i,
   input  logic             irq_disable_i,
   input  logic             brk_i,
   input  logic             cop_i,
   input  logic             emu_i,
   output intr_kind_e       kind_o,
   output logic [VEC_W-1:0] vec_o
);

   logic [15:0] emu_brk_vec;

   // Variant: break shares the maskable vector in emulation mode, or not.
   if (FOLD_BRK_EMU) begin : g_fold
      assign emu_brk_vec = EMU_IRQ_VEC;
   end else begin : g_split
      assign emu_brk_vec = NAT_BRK_VEC | 16'h0010;
   end

   always_comb begin
      if (nmi_pend_i)                      kind_o = KIND_NMI;
      else if (irq_any_i && !irq_disable_i) kind_o = KIND_IRQ;
      else if (brk_i)                      kind_o = KIND_BRK;
      else if (cop_i)                      kind_o = KIND_COP;
      else                                 kind_o = KIND_NONE;
   end

   logic [15:0] vec16;
   always_comb begin
      unique case (kind_o)
         KIND_NMI: vec16 = emu_i ? EMU_NMI_VEC : NAT_NMI_VEC;
         KIND_IRQ: vec16 = emu_i ? EMU_IRQ_VEC : NAT_IRQ_VEC;
         KIND_BRK: vec16 = emu_i ? emu_brk_vec : NAT_BRK_VEC;
         KIND_COP: vec16 = emu_i ? EMU_COP_VEC : NAT_COP_VEC;
         default:  vec16 = 16'h0000;
      endcase
   end

   assign vec_o = VEC_W'(vec16);

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
   import intr_arb_pkg::*;
#(
   parameter int NSRC         = 8,
   parameter int VEC_W        = 16,
   parameter bit FOLD_BRK_EMU = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  logic [NSRC-1:0]  src_set_i,
   input  logic [NSRC-1:0]  src_clr_i,
   input  logic             nmi_i,
   input  logic             irq_disable_i,
   input  logic             brk_i,
   input  logic             cop_i,
   input  logic             emu_load_i,
   input  logic             emu_value_i,
   output logic             take_o,
   output logic [VEC_W-1:0] vector_o,
   output logic             emu_mode_o,
   output logic [NSRC-1:0]  src_mask_o,
   output logic             irq_pending_o,
   output logic             nmi_pending_o
);

   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("intr_arbiter: NSRC must lie in 1..32");
   end
   if (VEC_W != 16) begin : g_bad_vecw
      $error("intr_arbiter: VEC_W must be 16");
   end
   if (VIDEO_SRC_BIT >= NSRC) begin : g_bad_video
      $error("intr_arbiter: video source bit outside mask");
   end

   logic             emu_q;
   logic             nmi_pend;
   logic             irq_any;
   logic             nmi_accept;
   intr_kind_e       kind;
   logic [VEC_W-1:0] sel_vec;
   logic             take_q;
   logic [VEC_W-1:0] vec_q;

   intr_src_mask #(.NSRC(NSRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set_i),
      .clr_i  (src_clr_i),
      .mask_o (src_mask_o),
      .any_o  (irq_any)
   );

   assign nmi_accept = boundary_i && (kind == KIND_NMI);

   intr_nmi_latch u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .nmi_i    (nmi_i),
      .accept_i (nmi_accept),
      .pend_o   (nmi_pend)
   );

   intr_vec_sel #(.VEC_W(VEC_W), .FOLD_BRK_EMU(FOLD_BRK_EMU)) u_sel (
      .nmi_pend_i    (nmi_pend),
      .irq_any_i     (irq_any),
      .irq_disable_i (irq_disable_i),
      .brk_i         (brk_i),
      .cop_i         (cop_i),
      .emu_i         (emu_q),
      .kind_o        (kind),
      .vec_o         (sel_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          emu_q <= 1'b1;
      else if (emu_load_i) emu_q <= emu_value_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= boundary_i && (kind != KIND_NONE);
         if (boundary_i && (kind != KIND_NONE)) vec_q <= sel_vec;
      end
   end

   assign take_o        = take_q;
   assign vector_o      = vec_q;
   assign emu_mode_o    = emu_q;
   assign irq_pending_o = irq_any;
   assign nmi_pending_o = nmi_pend;

   AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && nmi_pend) |=>
         (take_o && vector_o == ($past(emu_q) ? VEC_W'(EMU_NMI_VEC) : VEC_W'(NAT_NMI_VEC)))); // R5
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !nmi_pend && irq_disable_i && !brk_i && !cop_i) |=> !take_o); // R6
   AST_TAKE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i)); // R10
   AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(boundary_i) |-> $stable(vector_o)); // R10

endmodule

// File: tb/intr_arbiter_tb_top.sv
module intr_arbiter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;

   typedef struct packed {
      logic        emu;
      logic        nmi;
      logic [7:0]  mask;
      logic        dis;
      logic        brk;
      logic        cop;
      logic        take;
      logic [15:0] vec;
   } row_t;

   // emu, nmi edge, mask, disable, brk, cop, expected take, expected vector
   localparam row_t TBL [NV] = '{
      '{1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFA}, // R8 nmi emu
      '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFEA}, // R9 nmi native
      '{1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFE}, // R8 irq emu
      '{1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFEE}, // R9 irq native
      '{1'b1, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 masked
      '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFE}, // R8 brk folded
      '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFE6}, // R9 brk native
      '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFF4}, // R8 cop emu
      '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFE4}, // R9 cop native
      '{1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFEA}, // R5 nmi first
      '{1'b0, 1'b0, 8'h04, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFEE}, // R5 irq over brk
      '{1'b0, 1'b0, 8'h04, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFE6}, // R6 falls to brk
      '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFEA}, // R6 nmi ignores disable
      '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}  // R5 nothing pending
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        boundary_i, nmi_i, irq_disable_i, brk_i, cop_i, emu_load_i, emu_value_i;
   logic [7:0]  src_set_i, src_clr_i;
   logic        take_o, emu_mode_o, irq_pending_o, nmi_pending_o;
   logic [15:0] vector_o;
   logic [7:0]  src_mask_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
      .src_set_i(src_set_i), .src_clr_i(src_clr_i), .nmi_i(nmi_i),
      .irq_disable_i(irq_disable_i), .brk_i(brk_i), .cop_i(cop_i),
      .emu_load_i(emu_load_i), .emu_value_i(emu_value_i),
      .take_o(take_o), .vector_o(vector_o), .emu_mode_o(emu_mode_o),
      .src_mask_o(src_mask_o), .irq_pending_o(irq_pending_o),
      .nmi_pending_o(nmi_pending_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      rst_n = 1'b0; boundary_i = 1'b0; nmi_i = 1'b0; irq_disable_i = 1'b0;
      brk_i = 1'b0; cop_i = 1'b0; emu_load_i = 1'b0; emu_value_i = 1'b0;
      src_set_i = '0; src_clr_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tick();
      chk("R1 take", take_o, 0);
      chk("R1 vector", vector_o, 0);
      chk("R1 mask", src_mask_o, 0);
      chk("R1 nmi", nmi_pending_o, 0);
      chk("R1 emu", emu_mode_o, 1);
      chk("R3 idle", irq_pending_o, 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         emu_load_i = 1'b1; emu_value_i = TBL[i].emu; src_clr_i = '1; nmi_i = 1'b0;
         @(negedge clk);
         emu_load_i = 1'b0; src_clr_i = '0; src_set_i = TBL[i].mask; nmi_i = TBL[i].nmi;
         @(negedge clk);
         src_set_i = '0; irq_disable_i = TBL[i].dis; brk_i = TBL[i].brk;
         cop_i = TBL[i].cop; boundary_i = 1'b1;
         tick();
         chk($sformatf("R5 row %0d take", i), take_o, TBL[i].take);
         if (TBL[i].take)
            chk($sformatf("R8/R9 row %0d vector", i), vector_o, TBL[i].vec);
         @(negedge clk);
         boundary_i = 1'b0; brk_i = 1'b0; cop_i = 1'b0; irq_disable_i = 1'b0;
      end

      // R2 / R3: set and clear per bit
      @(negedge clk) src_set_i = 8'h0F; src_clr_i = 8'hFF; nmi_i = 1'b0;
      tick();
      chk("R2 set wins", src_mask_o, 8'h0F);
      chk("R3 any", irq_pending_o, 1);
      @(negedge clk) src_set_i = 8'h00; src_clr_i = 8'h02;
      tick();
      chk("R2 clear one bit", src_mask_o, 8'h0D);
      @(negedge clk) src_set_i = 8'h10; src_clr_i = 8'h11;
      tick();
      chk("R2 overlap", src_mask_o, 8'h1C);
      @(negedge clk) src_set_i = 8'h00; src_clr_i = 8'hFF;
      tick();
      chk("R3 none", irq_pending_o, 0);

      // R7: accepted IRQ leaves mask; native mode
      @(negedge clk) src_clr_i = 8'h00; src_set_i = 8'h20; emu_load_i = 1'b1; emu_value_i = 1'b0;
      @(negedge clk) src_set_i = 8'h00; emu_load_i = 1'b0; boundary_i = 1'b1;
      tick();
      chk("R7 irq take", take_o, 1);
      chk("R9 irq vec", vector_o, 16'hFFEE);
      chk("R7 mask kept", src_mask_o, 8'h20);
      @(negedge clk) boundary_i = 1'b0; src_clr_i = 8'hFF;
      @(negedge clk) src_clr_i = 8'h00;

      // R4 / R10: NMI held without boundary
      nmi_i = 1'b1;
      tick();
      chk("R4 latched", nmi_pending_o, 1);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R10 no boundary", take_o, 0);
         chk("R4 still pending", nmi_pending_o, 1);
      end
      @(negedge clk) boundary_i = 1'b1;
      tick();
      chk("R5 nmi take", take_o, 1);
      chk("R9 nmi vec", vector_o, 16'hFFEA);
      chk("R7 nmi cleared", nmi_pending_o, 0);
      @(negedge clk) boundary_i = 1'b0;
      tick();
      chk("R10 strobe ends", take_o, 0);
      chk("R10 vector holds", vector_o, 16'hFFEA);
      @(negedge clk) boundary_i = 1'b1;
      tick();
      chk("R4 level no retrigger", take_o, 0);
      chk("R10 vector still", vector_o, 16'hFFEA);
      @(negedge clk) boundary_i = 1'b0; nmi_i = 1'b0;

      // R11: emulation register load
      @(negedge clk) emu_load_i = 1'b1; emu_value_i = 1'b1;
      tick();
      chk("R11 loaded", emu_mode_o, 1);
      @(negedge clk) emu_load_i = 1'b0; emu_value_i = 1'b0;
      tick();
      chk("R11 held", emu_mode_o, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule